// File: doc/BRIEF.md
# Vector Type Configuration Register Bank

This block holds the type word of every architectural vector register and a single global cap on element width. Software reaches that state through one 64-bit read/write port that addresses either a configuration slot (four type words side by side) or the global cap. Every write is checked before it is committed. An accepted write updates the state and, one cycle later, emits a zeroing command for the vector data storage: either a unit-wide strobe or a per-register strobe vector. A rejected write changes nothing and raises a one-cycle illegal-instruction flag instead.

The per-register enable, shape, representation and width are exported as flat buses so that a separate length unit can derive the maximum vector length. Vector data storage and instruction decode live elsewhere.

Top module: `vcfg_bank`

## Requirements
- R1: After reset every type word and the global cap read as zero, all registers are disabled, and no flag or zeroing strobe is active.
- R2: Slot k holds registers 4k to 4k+3, and register 4k+j sits at bits 16j+15:16j of the slot. Inside a type word, bits 5:0 hold the width in bytes, bits 10:6 the representation and bits 15:11 the shape. Reading a slot returns exactly the words last committed.
- R3: An accepted slot write loads slot k, clears every slot above k, and leaves the slots below k unchanged.
- R4: A type word with a nonzero width is legal only with shape 0 (scalar) or 4 (1-D vector) and representation 0 (unsigned), 1 (signed) or 3 (floating point). A type word with zero width marks the register disabled and must be all zero.
- R5: A nonzero width must be 1, 2, 4 or 8 bytes, that is a power of two no larger than ELEN/8 (ELEN = 64).
- R6: After a slot write the enabled registers must form one contiguous run starting at register 0. A write that would break this is rejected.
- R7: A rejected write raises illegal_o for one cycle, emits no zeroing strobe, and leaves every type word and the cap unchanged.
- R8: A cap write is accepted when bits 63:6 are zero and the value is 0 or a legal width (R5) not below any enabled register's width. Every accepted cap write emits zero_all_o, even when the value is unchanged.
- R9: With a nonzero cap, a slot write carrying any width above the cap is rejected; an accepted slot write emits zero_reg_o for every register in the written slot and above, and never zero_all_o, even if widths change.
- R10: With a zero cap, an accepted slot write that changes the width of any register emits zero_all_o only; when no width changes it emits zero_reg_o for every register in the written slot and above.
- R11: illegal_o, zero_all_o and zero_reg_o are registered one-cycle pulses in the cycle after the write is presented, and stay low in any cycle that follows no write.
- R12: reg_en_o, reg_shape_o, reg_rep_o, reg_ew_o and maxew_o mirror the committed state; a register is enabled when its width is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_max_i | input | 1 | Write targets the global cap instead of a slot |
| wr_slot_i | input | 3 | Slot index for a slot write |
| wr_data_i | input | 64 | Write data |
| rd_max_i | input | 1 | Read the global cap instead of a slot |
| rd_slot_i | input | 3 | Slot index for a read |
| rd_data_o | output | 64 | Read data (cap zero-extended) |
| illegal_o | output | 1 | Rejected-write pulse |
| zero_all_o | output | 1 | Zero the whole vector unit |
| zero_reg_o | output | 32 | Per-register zero strobes |
| reg_en_o | output | 32 | Register enabled |
| reg_shape_o | output | 160 | Shape per register, 5 bits each |
| reg_rep_o | output | 160 | Representation per register, 5 bits each |
| reg_ew_o | output | 192 | Width in bytes per register, 6 bits each |
| maxew_o | output | 6 | Global width cap in bytes |

## Verification
Every cycle the assertions check that enabled registers stay contiguous from register 0, that no enabled width exceeds a nonzero cap, that a rejection never coincides with a zeroing strobe and leaves the state stable, that the two zeroing kinds never fire together, and that no pulse appears without a preceding write. Which writes are legal, which zeroing kind and mask a given write produces, the clearing of higher slots, the bit layout on the read port and the repeated cap write still zeroing the unit can only be shown by the bench's scenarios against its reference model.

// File: rtl/vcfg_pkg.sv
`timescale 1ns/1ps
package vcfg_pkg;
  localparam int TYPE_W  = 16;
  localparam int SHAPE_W = 5;
  localparam int REP_W   = 5;
  localparam int EW_W    = 6;

  typedef struct packed {
    logic [SHAPE_W-1:0] shape;
    logic [REP_W-1:0]   rep;
    logic [EW_W-1:0]    ew;
  } vtype_t;

  localparam logic [SHAPE_W-1:0] SHAPE_SCALAR = 5'd0;
  localparam logic [SHAPE_W-1:0] SHAPE_VEC1D  = 5'd4;
  localparam logic [REP_W-1:0]   REP_UINT     = 5'd0;
  localparam logic [REP_W-1:0]   REP_SINT     = 5'd1;
  localparam logic [REP_W-1:0]   REP_FLOAT    = 5'd3;

  function automatic logic ew_legal(input logic [EW_W-1:0] ew, input logic [EW_W-1:0] ew_top);
    return (ew != '0) && ((ew & (ew - 6'd1)) == '0) && (ew <= ew_top);
  endfunction
endpackage

// File: rtl/vcfg_word_check.sv
`timescale 1ns/1ps
module vcfg_word_check
  import vcfg_pkg::*;
#(
  parameter int ELEN = 64
) (
  input  vtype_t          word_i,
  input  logic [EW_W-1:0] maxew_i,
  output logic            ok_o
);
  localparam logic [EW_W-1:0] EW_TOP = EW_W'(ELEN / 8);

  logic shape_ok, rep_ok, ew_ok, cap_ok;

  always_comb begin
    shape_ok = (word_i.shape == SHAPE_SCALAR) || (word_i.shape == SHAPE_VEC1D);
    rep_ok   = (word_i.rep == REP_UINT) || (word_i.rep == REP_SINT) || (word_i.rep == REP_FLOAT);
    ew_ok    = ew_legal(word_i.ew, EW_TOP);
    cap_ok   = (maxew_i == '0) || (word_i.ew <= maxew_i);
    if (word_i.ew == '0) ok_o = (word_i == '0);  // disabled word carries no format
    else                 ok_o = shape_ok && rep_ok && ew_ok && cap_ok;
  end
endmodule

// File: rtl/vcfg_contig_check.sv
`timescale 1ns/1ps
module vcfg_contig_check #(
  parameter int NREGS = 32
) (
  input  logic [NREGS-1:0] en_i,
  output logic             ok_o
);
  logic [NREGS-1:0] gap;

  // a gap is an enabled register whose lower neighbour is disabled
  assign gap[0] = 1'b0;
  for (genvar g = 1; g < NREGS; g++) begin : g_gap
    assign gap[g] = en_i[g] & ~en_i[g-1];
  end

  assign ok_o = (gap == '0);
endmodule

// File: rtl/vcfg_bank.sv
`timescale 1ns/1ps
module vcfg_bank
  import vcfg_pkg::*;
#(
  parameter int NREGS = 32,
  parameter int XLEN  = 64,
  parameter int ELEN  = 64,
  localparam int RPS    = XLEN / TYPE_W,
  localparam int NSLOT  = NREGS / RPS,
  localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic                      wr_max_i,
  input  logic [SLOT_W-1:0]         wr_slot_i,
  input  logic [XLEN-1:0]           wr_data_i,
  input  logic                      rd_max_i,
  input  logic [SLOT_W-1:0]         rd_slot_i,
  output logic [XLEN-1:0]           rd_data_o,
  output logic                      illegal_o,
  output logic                      zero_all_o,
  output logic [NREGS-1:0]          zero_reg_o,
  output logic [NREGS-1:0]          reg_en_o,
  output logic [NREGS*SHAPE_W-1:0]  reg_shape_o,
  output logic [NREGS*REP_W-1:0]    reg_rep_o,
  output logic [NREGS*EW_W-1:0]     reg_ew_o,
  output logic [EW_W-1:0]           maxew_o
);
  localparam logic [EW_W-1:0] EW_TOP = EW_W'(ELEN / 8);

  vtype_t [NREGS-1:0] cfg_q, cfg_new;
  logic   [EW_W-1:0]  maxew_q;

  logic [NREGS-1:0] new_en, at_or_above, ew_diff, ew_over;
  logic [RPS-1:0]   lane_ok;
  logic             contig_ok, slot_ok, max_ok;
  logic [EW_W-1:0]  max_val;

  // ---- candidate state for a slot write
  always_comb begin
    for (int i = 0; i < NREGS; i++) begin
      if (i / RPS == int'(wr_slot_i))     cfg_new[i] = vtype_t'(wr_data_i[(i % RPS)*TYPE_W +: TYPE_W]);
      else if (i / RPS > int'(wr_slot_i)) cfg_new[i] = '0;
      else                                cfg_new[i] = cfg_q[i];
      new_en[i]      = (cfg_new[i].ew != '0);
      at_or_above[i] = (i / RPS >= int'(wr_slot_i));
      ew_diff[i]     = (cfg_new[i].ew != cfg_q[i].ew);
      ew_over[i]     = (cfg_q[i].ew > max_val);
    end
  end

  for (genvar l = 0; l < RPS; l++) begin : g_lane
    vcfg_word_check #(.ELEN(ELEN)) u_word (
      .word_i  (vtype_t'(wr_data_i[l*TYPE_W +: TYPE_W])),
      .maxew_i (maxew_q),
      .ok_o    (lane_ok[l])
    );
  end

  vcfg_contig_check #(.NREGS(NREGS)) u_contig (
    .en_i (new_en),
    .ok_o (contig_ok)
  );

  assign slot_ok = (&lane_ok) && contig_ok;

  // ---- cap write legality
  assign max_val = wr_data_i[EW_W-1:0];
  assign max_ok  = (wr_data_i[XLEN-1:EW_W] == '0) &&
                   ((max_val == '0) || (ew_legal(max_val, EW_TOP) && (ew_over == '0)));

  // ---- state and command pulses
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q      <= '0;
      maxew_q    <= '0;
      illegal_o  <= 1'b0;
      zero_all_o <= 1'b0;
      zero_reg_o <= '0;
    end else begin
      illegal_o  <= 1'b0;
      zero_all_o <= 1'b0;
      zero_reg_o <= '0;
      if (wr_en_i) begin
        if (wr_max_i) begin
          if (max_ok) begin
            maxew_q    <= max_val;
            zero_all_o <= 1'b1;
          end else begin
            illegal_o <= 1'b1;
          end
        end else if (slot_ok) begin
          cfg_q <= cfg_new;
          if ((maxew_q == '0) && (ew_diff != '0)) zero_all_o <= 1'b1;
          else                                     zero_reg_o <= at_or_above;
        end else begin
          illegal_o <= 1'b1;
        end
      end
    end
  end

  // ---- read port
  always_comb begin
    rd_data_o = '0;
    if (rd_max_i) rd_data_o[EW_W-1:0] = maxew_q;
    else          rd_data_o = cfg_q[rd_slot_i*RPS +: RPS];
  end

  // ---- exports
  for (genvar g = 0; g < NREGS; g++) begin : g_exp
    assign reg_en_o[g]                    = (cfg_q[g].ew != '0);
    assign reg_shape_o[g*SHAPE_W +: SHAPE_W] = cfg_q[g].shape;
    assign reg_rep_o[g*REP_W +: REP_W]    = cfg_q[g].rep;
    assign reg_ew_o[g*EW_W +: EW_W]       = cfg_q[g].ew;

    assert_cap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (maxew_o != '0) |-> (reg_ew_o[g*EW_W +: EW_W] <= maxew_o));
  end
  assign maxew_o = maxew_q;

  assert_contig_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_en_o & (reg_en_o + {{(NREGS-1){1'b0}}, 1'b1})) == '0);

  assert_reject_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!zero_all_o && (zero_reg_o == '0)));

  assert_reject_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> ($stable(reg_ew_o) && $stable(reg_rep_o) && $stable(reg_shape_o) && $stable(maxew_o)));

  assert_zero_kind_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(zero_all_o && (zero_reg_o != '0)));

  assert_no_spurious_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_en_i) |-> (!illegal_o && !zero_all_o && (zero_reg_o == '0)));
endmodule

// File: tb/tb_vcfg_bank.sv
`timescale 1ns/1ps
module tb_vcfg_bank;
  localparam int NREGS = 32;
  localparam int XLEN  = 64;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0, wr_max = 1'b0;
  logic [2:0]        wr_slot = '0;
  logic [XLEN-1:0]   wr_data = '0;
  logic              rd_max = 1'b0;
  logic [2:0]        rd_slot = '0;
  logic [XLEN-1:0]   rd_data;
  logic              illegal, zero_all;
  logic [NREGS-1:0]  zero_reg, reg_en;
  logic [NREGS*5-1:0] reg_shape, reg_rep;
  logic [NREGS*6-1:0] reg_ew;
  logic [5:0]        maxew;

  vcfg_bank dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_max_i(wr_max), .wr_slot_i(wr_slot), .wr_data_i(wr_data),
    .rd_max_i(rd_max), .rd_slot_i(rd_slot), .rd_data_o(rd_data),
    .illegal_o(illegal), .zero_all_o(zero_all), .zero_reg_o(zero_reg),
    .reg_en_o(reg_en), .reg_shape_o(reg_shape), .reg_rep_o(reg_rep),
    .reg_ew_o(reg_ew), .maxew_o(maxew)
  );

  always #10 clk = ~clk;  // 20 ns period

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference model
  logic [15:0] m_cfg [NREGS];
  logic [5:0]  m_max;

  typedef struct packed { logic ill; logic za; logic [NREGS-1:0] zr; } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];

  task automatic chk(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic ew_ok(logic [5:0] e);
    return (e == 6'd1) || (e == 6'd2) || (e == 6'd4) || (e == 6'd8);
  endfunction

  function automatic logic word_ok(logic [15:0] w);
    if (w[5:0] == 0) return w == 16'h0;
    return (w[15:11] == 5'd0 || w[15:11] == 5'd4) &&
           (w[10:6] == 5'd0 || w[10:6] == 5'd1 || w[10:6] == 5'd3) &&
           ew_ok(w[5:0]) && (m_max == 0 || w[5:0] <= m_max);
  endfunction

  function automatic logic [15:0] W(logic [4:0] s, logic [4:0] r, logic [5:0] e);
    return {s, r, e};
  endfunction

  function automatic logic [XLEN-1:0] slot_model(int s);
    logic [XLEN-1:0] v;
    for (int l = 0; l < 4; l++) v[l*16 +: 16] = m_cfg[s*4 + l];
    return v;
  endfunction

  task automatic push_write(logic mx, logic [2:0] s, logic [XLEN-1:0] d, exp_t e, string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_max = mx; wr_slot = s; wr_data = d;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    wr_en = 1'b0; wr_max = 1'b0;
  endtask

  task automatic write_slot(int s, logic [XLEN-1:0] d, string tag);
    logic [15:0] nw [NREGS];
    logic ok = 1'b1, diff = 1'b0;
    exp_t e = '0;
    for (int i = 0; i < NREGS; i++)
      nw[i] = (i/4 == s) ? d[(i%4)*16 +: 16] : ((i/4 > s) ? 16'h0 : m_cfg[i]);
    for (int l = 0; l < 4; l++) if (!word_ok(d[l*16 +: 16])) ok = 1'b0;
    for (int i = 1; i < NREGS; i++) if (nw[i][5:0] != 0 && nw[i-1][5:0] == 0) ok = 1'b0;
    if (!ok) e.ill = 1'b1;
    else begin
      for (int i = 0; i < NREGS; i++) if (nw[i][5:0] != m_cfg[i][5:0]) diff = 1'b1;
      if (m_max == 0 && diff) e.za = 1'b1;
      else for (int i = 0; i < NREGS; i++) e.zr[i] = (i/4 >= s);
      for (int i = 0; i < NREGS; i++) m_cfg[i] = nw[i];
    end
    push_write(1'b0, 3'(s), d, e, tag);
  endtask

  task automatic write_max(logic [XLEN-1:0] d, string tag);
    logic ok;
    exp_t e = '0;
    ok = (d[63:6] == 0) && (d[5:0] == 0 || ew_ok(d[5:0]));
    if (ok && d[5:0] != 0)
      for (int i = 0; i < NREGS; i++) if (m_cfg[i][5:0] > d[5:0]) ok = 1'b0;
    if (ok) begin e.za = 1'b1; m_max = d[5:0]; end
    else e.ill = 1'b1;
    push_write(1'b1, 3'd0, d, e, tag);
  endtask

  task automatic read_slot(int s, logic [XLEN-1:0] exp, string tag);
    @(negedge clk);
    rd_max = 1'b0; rd_slot = 3'(s);
    #1 chk(tag, rd_data, exp);
  endtask

  task automatic read_max(string tag);
    @(negedge clk);
    rd_max = 1'b1;
    #1 chk(tag, rd_data, {58'h0, m_max});
    rd_max = 1'b0;
  endtask

  task automatic check_exports(string tag);
    logic [NREGS-1:0]   en_e;
    logic [NREGS*6-1:0] ew_e;
    logic [NREGS*5-1:0] sh_e, rp_e;
    @(negedge clk);
    for (int i = 0; i < NREGS; i++) begin
      en_e[i] = m_cfg[i][5:0] != 0;
      ew_e[i*6 +: 6] = m_cfg[i][5:0];
      rp_e[i*5 +: 5] = m_cfg[i][10:6];
      sh_e[i*5 +: 5] = m_cfg[i][15:11];
    end
    chk({tag, " en"}, {32'h0, reg_en}, {32'h0, en_e});
    chk({tag, " ew lo"}, reg_ew[63:0], ew_e[63:0]);
    chk({tag, " ew hi"}, reg_ew[191:128], ew_e[191:128]);
    chk({tag, " rep"}, reg_rep[63:0], rp_e[63:0]);
    chk({tag, " shape"}, reg_shape[63:0], sh_e[63:0]);
    chk({tag, " cap"}, {58'h0, maxew}, {58'h0, m_max});
  endtask

  // monitor: pops one expected item per write, else expects silence
  initial begin
    exp_t e;
    string t;
    @(posedge rst_n);
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin e = exp_q.pop_front(); t = tag_q.pop_front(); end
      else begin e = '0; t = "R11 idle"; end
      chk({t, " illegal"}, {63'h0, illegal}, {63'h0, e.ill});
      chk({t, " zero_all"}, {63'h0, zero_all}, {63'h0, e.za});
      chk({t, " zero_reg"}, {32'h0, zero_reg}, {32'h0, e.zr});
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [XLEN-1:0] d0, d1;
    for (int i = 0; i < NREGS; i++) m_cfg[i] = '0;
    m_max = '0;
    #45 rst_n = 1'b1;

    // R1 reset state
    for (int s = 0; s < 8; s++) read_slot(s, 64'h0, "R1 slot");
    read_max("R1 cap");
    check_exports("R1");

    // R2 / R10 first slot write, widths change with zero cap
    d0 = {W(5'd4, 5'd0, 6'd8), W(5'd0, 5'd0, 6'd1), W(5'd4, 5'd1, 6'd2), W(5'd4, 5'd3, 6'd4)};
    write_slot(0, d0, "R10 width change");
    read_slot(0, 64'h2008_0001_2042_20C4, "R2 layout");
    d1 = {4{W(5'd4, 5'd0, 6'd1)}};
    write_slot(1, d1, "R10 slot1");
    read_slot(0, d0, "R3 lower kept");
    read_slot(1, d1, "R2 slot1");
    write_slot(1, d1, "R10 same widths");
    write_slot(1, {4{W(5'd0, 5'd1, 6'd1)}}, "R10 format only");
    read_slot(1, slot_model(1), "R2 format read");
    write_slot(0, d0, "R3 clears above");
    read_slot(1, 64'h0, "R3 higher cleared");
    write_slot(1, d1, "R10 restore");

    // R4 / R5 / R6 rejections
    write_slot(2, {48'h0, W(5'd1, 5'd0, 6'd1)}, "R4 bad shape");
    write_slot(2, {48'h0, W(5'd4, 5'd2, 6'd1)}, "R4 bad rep");
    write_slot(2, {W(5'd0, 5'd1, 6'd0), W(5'd4, 5'd0, 6'd1), W(5'd4, 5'd0, 6'd1), W(5'd4, 5'd0, 6'd1)}, "R4 dirty disabled");
    write_slot(2, {48'h0, W(5'd4, 5'd0, 6'd3)}, "R5 width 3");
    write_slot(2, {48'h0, W(5'd4, 5'd0, 6'd16)}, "R5 width 16");
    write_slot(2, {16'h0, W(5'd4, 5'd0, 6'd1), 16'h0, W(5'd4, 5'd0, 6'd1)}, "R6 gap");
    write_slot(3, {48'h0, W(5'd4, 5'd0, 6'd1)}, "R6 hole below");
    read_slot(0, d0, "R7 slot0 held");
    read_slot(1, d1, "R7 slot1 held");
    read_slot(2, 64'h0, "R7 slot2 held");
    check_exports("R7");

    // R8 cap writes
    write_max(64'd3, "R8 cap 3");
    write_max(64'd4, "R8 cap below width");
    write_max(64'd8, "R8 cap 8");
    write_max(64'd8, "R8 cap repeat");
    write_max(64'h108, "R8 cap upper bits");
    read_max("R8 cap read");

    // R9 nonzero cap
    write_slot(1, {4{W(5'd4, 5'd1, 6'd8)}}, "R9 width change no unit zero");
    write_slot(0, {4{W(5'd4, 5'd0, 6'd2)}}, "R9 slot0");
    write_max(64'd2, "R8 cap 2");
    write_slot(1, {48'h0, W(5'd4, 5'd0, 6'd4)}, "R9 over cap");
    write_slot(1, {4{W(5'd0, 5'd3, 6'd2)}}, "R9 at cap");
    write_slot(1, {4{W(5'd4, 5'd0, 6'd1)}}, "R9 narrower");
    read_slot(1, slot_model(1), "R9 readback");
    check_exports("R12 capped");

    write_max(64'd0, "R8 cap clear");
    read_max("R8 cap zero");
    write_slot(0, 64'h0, "R10 disable all");
    check_exports("R12 final");

    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule